// File: doc/BRIEF.md
# Defect-Tolerant Multi-Bus Cache Bank Manager

This block steers accesses into a second-level cache assembled from a number of identical array banks. A per-bank fuse input marks banks found defective, and a power register written by software switches banks on or off one by one. Only banks that are powered, fuse-intact and still reachable over at least one bus branch count as usable. The linear cache index is laid across the usable banks only, so the capacity seen by software is the usable bank count times one bank's line count, which need not be a power of two.

Several requester ports present indices in the same cycle. Each bank hangs on every shared bus through its own branch, and a mask flags broken branches. The block picks a healthy, still-free bus for every accepted request, so distinct banks are served in parallel like a multiport memory. A request that loses a bank or bus race is held off with a same-cycle stall and retried by its owner. An index past the usable capacity returns an error pulse instead of touching any bank. A bank is never switched off while an access to it is in flight; the off request waits until the bank is idle.

Top module: `cbm_bank_mgr`

## Requirements
- R1: While `rst` is high, `bank_en`, `bank_act`, `rsp_vld` and `rsp_oor` are all zero and every power bit is on; one clock edge after reset drops, every bank that is fuse-intact and has a healthy branch shows `bank_en` high.
- R2: A bank whose `fuse_bad` bit is 1 has `bank_en` low (supply and bus driver off) from the next edge on and never shows `bank_act`.
- R3: A request index splits as rank = `req_idx[IDXW-1:LINE_W]` and line = `req_idx[LINE_W-1:0]`; rank k goes to the k-th usable bank counting upward from bank 0, and `rsp_line` returns the line field.
- R4: Capacity is the usable bank count times 2^LINE_W; a valid request whose rank is not below the usable count gives `rsp_oor` high one edge later, no `rsp_vld`, no `bank_act`, and no stall.
- R5: A write with `pwr_we` high sets the power target from `pwr_wdata` (bit b = 1 on, 0 off); an idle bank follows the target at the next edge, and usability and the index map follow at once.
- R6: A bank that has an access granted in the current cycle, or shows `bank_act`, keeps its power on; a pending off takes effect at the first edge where it is idle.
- R7: `bus_fault` bit b*NBUS+u flags the branch from bank b to bus u as broken; an accepted request uses the lowest-numbered bus whose branch to its bank is healthy and that no lower-numbered port took this cycle, and that bus is shown on `bank_bus` for that bank.
- R8: A bank whose branches to all buses are broken drops out of the usable set at the next edge and leaves the index map.
- R9: When two ports target the same bank in one cycle, the lower-numbered port is accepted and the higher one sees `req_stall` high in that same cycle; the stalled request is accepted once it is retried without conflict.
- R10: Requests to different banks are accepted in the same cycle on distinct buses; a request that finds no free healthy bus is stalled.
- R11: For an accepted request, `rsp_vld`, `rsp_bank`, `rsp_line`, `bank_act` and `bank_bus` are registered and appear one edge after the request cycle, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_bad | input | NBANK | 1 marks a defective bank |
| bus_fault | input | NBANK*NBUS | 1 marks a broken branch, bit b*NBUS+u for bank b, bus u |
| pwr_we | input | 1 | Power register write strobe |
| pwr_wdata | input | NBANK | Power target per bank, 1 = on |
| req_vld | input | NPORT | Request valid per port |
| req_idx | input | NPORT*IDXW | Linear cache index per port, port p at bits p*IDXW |
| req_stall | output | NPORT | Request not accepted this cycle, hold and retry |
| rsp_vld | output | NPORT | Accepted access presented this cycle |
| rsp_oor | output | NPORT | Index beyond usable capacity |
| rsp_bank | output | NPORT*BKW | Bank chosen for the port |
| rsp_line | output | NPORT*LINE_W | Line inside the bank |
| bank_en | output | NBANK | Bank usable: supply and bus driver on |
| bank_act | output | NBANK | Bank accessed this cycle |
| bank_bus | output | NBANK*BUSW | Bus carrying the bank's access |

## Verification
The checker watches every cycle that no bus carries two banks at once, that an accessed bank was enabled and reached over a healthy branch, that fused banks stay off, that a response is never both valid and out of range, and that a bank never loses power in the cycles around an access. Which bank a given index lands on, the error at the capacity boundary, the port priority on a bank clash, bus fallback and exhaustion, and the delay of a power-off behind traffic depend on chosen mask and index combinations, and only the directed scenarios show them against independently computed bank numbers.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  // Position of the lowest set bit, or -1 when none is set.
  function automatic int lowest_one(input logic [31:0] v);
    int pos;
    pos = -1;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) pos = i;
    end
    return pos;
  endfunction

endpackage

// File: rtl/cbm_rank_map.sv
module cbm_rank_map #(
  parameter int NBANK = 6,
  parameter int BKW   = 3,
  parameter int CNTW  = 3,
  localparam int NRANK = 1 << BKW
) (
  input  logic [NBANK-1:0]     usable,
  output logic [CNTW-1:0]      cnt,
  output logic [NRANK*BKW-1:0] rank_bank
);

  // Rank k lands on the k-th usable bank, lowest bank first.
  always_comb begin
    int acc;
    acc = 0;
    rank_bank = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (usable[b]) begin
        rank_bank[acc*BKW +: BKW] = BKW'(b);
        acc = acc + 1;
      end
    end
    cnt = CNTW'(acc);
  end

endmodule

// File: rtl/cbm_port_arb.sv
module cbm_port_arb #(
  parameter int NBANK  = 6,
  parameter int NBUS   = 2,
  parameter int NPORT  = 2,
  parameter int LINE_W = 4,
  parameter int BKW    = 3,
  parameter int BUSW   = 1,
  parameter int CNTW   = 3,
  localparam int IDXW  = BKW + LINE_W,
  localparam int NRANK = 1 << BKW
) (
  input  logic [NPORT-1:0]        req_vld,
  input  logic [NPORT*IDXW-1:0]   req_idx,
  input  logic [CNTW-1:0]         cnt,
  input  logic [NRANK*BKW-1:0]    rank_bank,
  input  logic [NBANK*NBUS-1:0]   bus_fault,
  output logic [NPORT-1:0]        gnt,
  output logic [NPORT-1:0]        oor,
  output logic [NPORT-1:0]        stall,
  output logic [NPORT*BKW-1:0]    p_bank,
  output logic [NPORT*BUSW-1:0]   p_bus,
  output logic [NPORT*LINE_W-1:0] p_line
);
  import cbm_pkg::*;

  always_comb begin
    logic [NBUS-1:0]  taken_bus;
    logic [NBANK-1:0] taken_bank;
    logic [BKW-1:0]   rank;
    logic [BKW-1:0]   bk;
    logic [NBUS-1:0]  free_bus;
    int               pick;
    taken_bus  = '0;
    taken_bank = '0;
    gnt    = '0;
    oor    = '0;
    stall  = '0;
    p_bank = '0;
    p_bus  = '0;
    p_line = '0;
    // Lower port numbers claim banks and buses first.
    for (int p = 0; p < NPORT; p++) begin
      rank = req_idx[p*IDXW+LINE_W +: BKW];
      bk   = rank_bank[int'(rank)*BKW +: BKW];
      free_bus = ~bus_fault[int'(bk)*NBUS +: NBUS] & ~taken_bus;
      pick = lowest_one(32'(free_bus));
      p_line[p*LINE_W +: LINE_W] = req_idx[p*IDXW +: LINE_W];
      p_bank[p*BKW +: BKW] = bk;
      if (req_vld[p]) begin
        if (int'(rank) >= int'(cnt)) begin
          oor[p] = 1'b1;
        end else if (!taken_bank[bk] && pick >= 0) begin
          gnt[p] = 1'b1;
          p_bus[p*BUSW +: BUSW] = BUSW'(pick);
          taken_bank[bk] = 1'b1;
          taken_bus[pick] = 1'b1;
        end else begin
          stall[p] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cbm_pwr_ctl.sv
module cbm_pwr_ctl #(
  parameter int NBANK = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_we,
  input  logic [NBANK-1:0] pwr_wdata,
  input  logic [NBANK-1:0] busy,
  output logic [NBANK-1:0] pwr_nxt
);

  logic [NBANK-1:0] tgt_q;
  logic [NBANK-1:0] pwr_q;
  logic [NBANK-1:0] tgt;

  assign tgt = pwr_we ? pwr_wdata : tgt_q;

  // Switching on is immediate; switching off waits for an idle bank.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign pwr_nxt[b] = rst ? 1'b1 : (tgt[b] | (pwr_q[b] & busy[b]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '1;
      pwr_q <= '1;
    end else begin
      tgt_q <= tgt;
      pwr_q <= pwr_nxt;
    end
  end

endmodule

// File: rtl/cbm_bank_mgr.sv
module cbm_bank_mgr #(
  parameter int NBANK  = 6,
  parameter int NBUS   = 2,
  parameter int NPORT  = 2,
  parameter int LINE_W = 4,
  localparam int BKW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int BUSW  = (NBUS > 1) ? $clog2(NBUS) : 1,
  localparam int IDXW  = BKW + LINE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NBANK-1:0]        fuse_bad,
  input  logic [NBANK*NBUS-1:0]   bus_fault,
  input  logic                    pwr_we,
  input  logic [NBANK-1:0]        pwr_wdata,
  input  logic [NPORT-1:0]        req_vld,
  input  logic [NPORT*IDXW-1:0]   req_idx,
  output logic [NPORT-1:0]        req_stall,
  output logic [NPORT-1:0]        rsp_vld,
  output logic [NPORT-1:0]        rsp_oor,
  output logic [NPORT*BKW-1:0]    rsp_bank,
  output logic [NPORT*LINE_W-1:0] rsp_line,
  output logic [NBANK-1:0]        bank_en,
  output logic [NBANK-1:0]        bank_act,
  output logic [NBANK*BUSW-1:0]   bank_bus
);

  localparam int CNTW  = $clog2(NBANK + 1);
  localparam int NRANK = 1 << BKW;

  logic [NBANK-1:0]        bank_en_q;
  logic [NBANK-1:0]        act_q;
  logic [NBANK*BUSW-1:0]   bus_q;
  logic [NPORT-1:0]        rvld_q;
  logic [NPORT-1:0]        roor_q;
  logic [NPORT*BKW-1:0]    rbank_q;
  logic [NPORT*LINE_W-1:0] rline_q;

  logic [CNTW-1:0]         cnt;
  logic [NRANK*BKW-1:0]    rank_bank;
  logic [NPORT-1:0]        gnt;
  logic [NPORT-1:0]        oor;
  logic [NPORT-1:0]        stall;
  logic [NPORT*BKW-1:0]    p_bank;
  logic [NPORT*BUSW-1:0]   p_bus;
  logic [NPORT*LINE_W-1:0] p_line;
  logic [NBANK-1:0]        reach;
  logic [NBANK-1:0]        gnt_bank;
  logic [NBANK*BUSW-1:0]   gnt_bus;
  logic [NBANK-1:0]        busy;
  logic [NBANK-1:0]        pwr_nxt;

  // A bank is reachable while at least one of its branches works.
  for (genvar b = 0; b < NBANK; b++) begin : g_reach
    assign reach[b] = ~&bus_fault[b*NBUS +: NBUS];
  end

  cbm_rank_map #(.NBANK(NBANK), .BKW(BKW), .CNTW(CNTW)) u_map (
    .usable    (bank_en_q),
    .cnt       (cnt),
    .rank_bank (rank_bank)
  );

  cbm_port_arb #(
    .NBANK(NBANK), .NBUS(NBUS), .NPORT(NPORT), .LINE_W(LINE_W),
    .BKW(BKW), .BUSW(BUSW), .CNTW(CNTW)
  ) u_arb (
    .req_vld   (req_vld),
    .req_idx   (req_idx),
    .cnt       (cnt),
    .rank_bank (rank_bank),
    .bus_fault (bus_fault),
    .gnt       (gnt),
    .oor       (oor),
    .stall     (stall),
    .p_bank    (p_bank),
    .p_bus     (p_bus),
    .p_line    (p_line)
  );

  // Spread port grants onto the bank side.
  always_comb begin
    gnt_bank = '0;
    gnt_bus  = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (gnt[p]) begin
        gnt_bank[p_bank[p*BKW +: BKW]] = 1'b1;
        gnt_bus[int'(p_bank[p*BKW +: BKW])*BUSW +: BUSW] = p_bus[p*BUSW +: BUSW];
      end
    end
  end

  assign busy = gnt_bank | act_q;

  cbm_pwr_ctl #(.NBANK(NBANK)) u_pwr (
    .clk       (clk),
    .rst       (rst),
    .pwr_we    (pwr_we),
    .pwr_wdata (pwr_wdata),
    .busy      (busy),
    .pwr_nxt   (pwr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_en_q <= '0;
      act_q     <= '0;
      bus_q     <= '0;
      rvld_q    <= '0;
      roor_q    <= '0;
      rbank_q   <= '0;
      rline_q   <= '0;
    end else begin
      bank_en_q <= pwr_nxt & ~fuse_bad & reach;
      act_q     <= gnt_bank;
      bus_q     <= gnt_bus;
      rvld_q    <= gnt;
      roor_q    <= oor;
      rbank_q   <= p_bank;
      rline_q   <= p_line;
    end
  end

  assign req_stall = stall;
  assign rsp_vld   = rvld_q;
  assign rsp_oor   = roor_q;
  assign rsp_bank  = rbank_q;
  assign rsp_line  = rline_q;
  assign bank_en   = bank_en_q;
  assign bank_act  = act_q;
  assign bank_bus  = bus_q;

endmodule

// File: rtl/cbm_chk.sv
module cbm_chk #(
  parameter int NBANK  = 6,
  parameter int NBUS   = 2,
  parameter int NPORT  = 2,
  parameter int LINE_W = 4,
  localparam int BKW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int BUSW  = (NBUS > 1) ? $clog2(NBUS) : 1,
  localparam int IDXW  = BKW + LINE_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NBANK-1:0]        fuse_bad,
  input logic [NBANK*NBUS-1:0]   bus_fault,
  input logic [NPORT-1:0]        req_vld,
  input logic [NPORT-1:0]        req_stall,
  input logic [NPORT-1:0]        rsp_vld,
  input logic [NPORT-1:0]        rsp_oor,
  input logic [NPORT*BKW-1:0]    rsp_bank,
  input logic [NBANK-1:0]        bank_en,
  input logic [NBANK-1:0]        bank_act,
  input logic [NBANK*BUSW-1:0]   bank_bus
);

  logic [NBANK*NBUS-1:0] fault_d;
  always_ff @(posedge clk) fault_d <= bus_fault;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    // R2
    fused_off_chk: assert property (@(posedge clk) disable iff (rst)
      $past(fuse_bad[b]) |-> !bank_en[b]);
    // R2
    act_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
      bank_act[b] |-> $past(bank_en[b]));
    // R7
    healthy_branch_chk: assert property (@(posedge clk) disable iff (rst)
      bank_act[b] |-> !fault_d[b*NBUS + int'(bank_bus[b*BUSW +: BUSW])]);
    // R6
    no_off_busy_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(bank_en[b]) && !$past(fuse_bad[b]) &&
       $past(~&bus_fault[b*NBUS +: NBUS]))
      |-> (!$past(bank_act[b]) && !bank_act[b]));
  end

  for (genvar u = 0; u < NBUS; u++) begin : g_bus
    logic [NBANK-1:0] users;
    always_comb begin
      for (int b = 0; b < NBANK; b++)
        users[b] = bank_act[b] && (int'(bank_bus[b*BUSW +: BUSW]) == u);
    end
    // R10
    one_user_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(users));
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    // R4
    vld_xor_oor_chk: assert property (@(posedge clk) disable iff (rst)
      !(rsp_vld[p] && rsp_oor[p]));
    // R9
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      req_stall[p] |-> req_vld[p]);
    // R11
    rsp_bank_act_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_vld[p] |-> bank_act[rsp_bank[p*BKW +: BKW]]);
  end

endmodule

bind cbm_bank_mgr cbm_chk #(
  .NBANK(NBANK), .NBUS(NBUS), .NPORT(NPORT), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst(rst), .fuse_bad(fuse_bad), .bus_fault(bus_fault),
  .req_vld(req_vld), .req_stall(req_stall), .rsp_vld(rsp_vld),
  .rsp_oor(rsp_oor), .rsp_bank(rsp_bank), .bank_en(bank_en),
  .bank_act(bank_act), .bank_bus(bank_bus)
);

// File: tb/sim_cbm_bank_mgr.sv
module sim_cbm_bank_mgr;
  localparam int NB = 6, NU = 2, NP = 2, LW = 4, BKW = 3, IW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] fuse_bad = '0;
  logic [NB*NU-1:0] bus_fault = '0;
  logic          pwr_we = 1'b0;
  logic [NB-1:0] pwr_wdata = '0;
  logic [NP-1:0] req_vld = '0;
  logic [NP*IW-1:0] req_idx = '0;
  logic [NP-1:0] req_stall, rsp_vld, rsp_oor;
  logic [NP*BKW-1:0] rsp_bank;
  logic [NP*LW-1:0]  rsp_line;
  logic [NB-1:0] bank_en, bank_act;
  logic [NB-1:0] bank_bus;
  logic [NP-1:0] st;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cbm_bank_mgr #(.NBANK(NB), .NBUS(NU), .NPORT(NP), .LINE_W(LW)) u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent model: k-th set bit of the usable mask.
  function automatic int exp_bank(input logic [NB-1:0] en, input int rank);
    int k = 0;
    for (int b = 0; b < NB; b++) begin
      if (en[b]) begin
        if (k == rank) return b;
        k++;
      end
    end
    return -1;
  endfunction

  function automatic int idx(input int rank, input int line);
    return rank * 16 + line;
  endfunction

  // Drive one cycle of requests; stall sampled before the edge,
  // registered outputs valid right after it.
  task automatic issue(input logic v0, input int i0, input logic v1, input int i1);
    @(negedge clk);
    req_vld = {v1, v0};
    req_idx = {IW'(i1), IW'(i0)};
    #1 st = req_stall;
    @(posedge clk);
    #1;
    req_vld = '0;
    pwr_we = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    settle();
    check("R1 en in reset", int'(bank_en), 0);
    check("R1 act in reset", int'(bank_act), 0);
    check("R1 rsp in reset", int'({rsp_vld, rsp_oor}), 0);
    @(negedge clk) rst = 1'b0;
    settle();
    check("R1 en after reset", int'(bank_en), 6'h3F);
  endtask

  task automatic t_map();
    issue(1, idx(2, 5), 0, 0);
    check("R3 bank", int'(rsp_bank[2:0]), exp_bank(6'h3F, 2));
    check("R3 line", int'(rsp_line[3:0]), 5);
    check("R11 vld", int'(rsp_vld), 1);
    check("R11 act", int'(bank_act), 6'b000100);
    settle();
    check("R11 one cycle", int'(bank_act), 0);
  endtask

  task automatic t_fuse();
    @(negedge clk) fuse_bad = 6'b001010;
    settle();
    check("R2 en", int'(bank_en), 6'b110101);
    issue(1, idx(2, 3), 0, 0);
    check("R3 fused rank2", int'(rsp_bank[2:0]), exp_bank(6'b110101, 2));
    check("R2 fused untouched", int'(bank_act & 6'b001010), 0);
    issue(1, idx(3, 15), 0, 0);
    check("R4 last line bank", int'(rsp_bank[2:0]), 5);
    check("R4 last line vld", int'(rsp_vld[0]), 1);
    issue(1, idx(4, 0), 0, 0);
    check("R4 oor", int'(rsp_oor[0]), 1);
    check("R4 no vld", int'(rsp_vld[0]), 0);
    check("R4 no act", int'(bank_act), 0);
    check("R4 no stall", int'(st), 0);
    issue(0, 0, 1, idx(7, 2));
    check("R4 oor rank7 p1", int'(rsp_oor), 2);
    @(negedge clk) fuse_bad = '0;
    settle();
  endtask

  task automatic t_pwr();
    @(negedge clk); pwr_we = 1; pwr_wdata = 6'h3E;
    settle(); pwr_we = 0;
    check("R5 off idle", int'(bank_en), 6'h3E);
    issue(1, idx(0, 1), 0, 0);
    check("R5 remap", int'(rsp_bank[2:0]), exp_bank(6'h3E, 0));
    @(negedge clk); pwr_we = 1; pwr_wdata = 6'h3F;
    settle(); pwr_we = 0;
    check("R5 on", int'(bank_en), 6'h3F);
  endtask

  task automatic t_defer();
    @(negedge clk);
    pwr_we = 1; pwr_wdata = 6'b110111;
    req_vld = 2'b01; req_idx = {IW'(0), IW'(idx(3, 0))};
    settle();
    pwr_we = 0; req_vld = '0;
    check("R6 held while granted", int'(bank_en[3]), 1);
    check("R6 access out", int'(bank_act[3]), 1);
    settle();
    check("R6 held while active", int'(bank_en[3]), 1);
    settle();
    check("R6 off when idle", int'(bank_en[3]), 0);
    @(negedge clk); pwr_we = 1; pwr_wdata = 6'h3F;
    settle(); pwr_we = 0;
    check("R5 restored", int'(bank_en), 6'h3F);
  endtask

  task automatic t_conflict();
    issue(1, idx(1, 0), 1, idx(1, 4));
    check("R9 p1 stalled", int'(st), 2);
    check("R9 p0 wins", int'(rsp_vld), 1);
    check("R9 p0 bank", int'(rsp_bank[2:0]), 1);
    issue(0, 0, 1, idx(1, 4));
    check("R9 retry ok", int'(rsp_vld), 2);
    check("R9 retry line", int'(rsp_line[7:4]), 4);
  endtask

  task automatic t_multi();
    issue(1, idx(0, 0), 1, idx(4, 0));
    check("R10 both", int'(rsp_vld), 3);
    check("R10 acts", int'(bank_act), 6'b010001);
    check("R7 p0 bus0", int'(bank_bus[0]), 0);
    check("R7 p1 bus1", int'(bank_bus[4]), 1);
  endtask

  task automatic t_fault();
    @(negedge clk) bus_fault = 12'b0000_0001_0000;
    settle();
    issue(1, idx(2, 0), 0, 0);
    check("R7 fallback bank", int'(rsp_bank[2:0]), 2);
    check("R7 fallback bus", int'(bank_bus[2]), 1);
    @(negedge clk) bus_fault = 12'b0000_0011_0000;
    settle();
    check("R8 dropped", int'(bank_en), 6'b111011);
    issue(1, idx(2, 0), 0, 0);
    check("R8 remap", int'(rsp_bank[2:0]), exp_bank(6'b111011, 2));
    @(negedge clk) bus_fault = 12'b0000_0000_0101;
    settle();
    issue(1, idx(0, 0), 1, idx(1, 0));
    check("R10 no bus stall", int'(st), 2);
    check("R10 p0 on bus1", int'(bank_bus[0]), 1);
    check("R10 only p0", int'(rsp_vld), 1);
    @(negedge clk) bus_fault = '0;
    settle();
  endtask

  initial begin
    t_reset();
    t_map();
    t_fuse();
    t_pwr();
    t_defer();
    t_conflict();
    t_multi();
    t_fault();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule